// File: doc/BRIEF.md
# Hardware Stack Pointer Engine

This block keeps the stack pointer of a small 8-bit processor core and carries out every stack transfer between the core and its data SRAM. The stack grows toward lower addresses. A requester asks for one of four operations:

- a single data byte pushed;
- a single data byte popped;
- a two-byte return address pushed, for a call or interrupt entry;
- a two-byte return address popped, for a return.

For each byte moved, the engine drives the SRAM address, write data, write strobe and read strobe. Popped bytes and popped return addresses come back to the requester on registered outputs.

Software sees the pointer as two byte-wide registers, low and high, each with its own write strobe and its own read port. For very small data spaces, a build parameter removes the high register. The pointer then shrinks to 8 bits, and the high read port returns zero. Pointer arithmetic always wraps modulo the pointer width. Checking that the stack stays in a legal region is left to software.

Top module: `stkptr_engine`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the pointer reads 0x0000, busy is low, req_ready is high, and neither mem_we nor mem_re is asserted.
- R2: A byte push (req_op 2'b00) accepted in a cycle writes req_wdata at the current pointer address in that same cycle (mem_we high), and the pointer is one lower after the edge.
- R3: A byte pop (req_op 2'b01) reads in its accept cycle from pointer+1 (mem_re high), and the pointer is one higher after the edge. One cycle later, pop_valid pulses for one cycle with the byte read on pop_byte.
- R4: A return-address push (req_op 2'b10) takes two cycles. The first cycle writes req_addr[7:0] at the pointer. The second writes req_addr[15:8] at pointer-1 while busy is high. The pointer ends two lower.
- R5: A return-address pop (req_op 2'b11) takes two cycles. It first reads the high byte from pointer+1, then, with busy high, reads the low byte from pointer+2. The pointer ends two higher. One cycle after the second read, ret_valid pulses with {high, low} on ret_addr.
- R6: A write strobe on sw_wr_lo or sw_wr_hi loads sw_wdata into pointer bits 7:0 or 15:8 respectively. sw_rd_lo and sw_rd_hi always show those bits.
- R7: When a software write and a stack request fall in the same idle cycle, the software write takes effect. req_ready is low in that cycle, no SRAM access occurs, and the request is dropped.
- R8: A software write during the second cycle of a two-byte operation abandons that second cycle. No SRAM access occurs in it, no ret_valid follows, the pointer takes the written value, and the unit returns to idle.
- R9: Pointer arithmetic wraps. A pop at 0xFFFF reads address 0x0000 and leaves the pointer at 0x0000. A push at 0x0000 writes address 0x0000 and leaves the pointer at 0xFFFF.
- R10: While busy is high, req_ready is low and any request is ignored; the pointer moves only by the in-flight operation.
- R11: With HAS_HIGH_BYTE = 0, the pointer is 8 bits. sw_rd_hi reads 0, sw_wr_hi has no effect, mem_addr[15:8] is 0, and arithmetic wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Stack request present |
| req_op | input | 2 | 00 push byte, 01 pop byte, 10 push return address, 11 pop return address |
| req_wdata | input | 8 | Byte to push |
| req_addr | input | 16 | Return address to push |
| req_ready | output | 1 | Request is accepted this cycle |
| busy | output | 1 | Second cycle of a two-byte transfer |
| sw_wr_lo | input | 1 | Software write strobe, pointer low byte |
| sw_wr_hi | input | 1 | Software write strobe, pointer high byte |
| sw_wdata | input | 8 | Software write data |
| sw_rd_lo | output | 8 | Pointer low byte |
| sw_rd_hi | output | 8 | Pointer high byte (zero without the high register) |
| mem_addr | output | 16 | SRAM byte address |
| mem_wdata | output | 8 | SRAM write data |
| mem_we | output | 1 | SRAM write strobe |
| mem_re | output | 1 | SRAM read strobe |
| mem_rdata | input | 8 | SRAM read data, valid in the same cycle as the address |
| pop_valid | output | 1 | One-cycle pulse: pop_byte holds a popped byte |
| pop_byte | output | 8 | Popped data byte |
| ret_valid | output | 1 | One-cycle pulse: ret_addr holds a popped return address |
| ret_addr | output | 16 | Popped return address |

## Verification
A software write to a pointer byte can land in the same cycle as a stack step, either when a new request is offered or during the second cycle of a two-byte transfer. The bench provokes both cases. It raises a write strobe together with a byte push in an idle cycle, and raises it again in the high-byte cycle of a return-address push. It then judges the outcome by three things: that no SRAM strobe appeared in that cycle, that req_ready was low, and that the pointer read back afterwards holds the written byte with no step applied.

// File: rtl/stkptr_pkg.sv
// Shared encodings for the stack pointer engine.
// Assumes: the requester drives the two-bit operation code defined below.
package stkptr_pkg;

    typedef enum logic [1:0] {
        OP_PUSH_BYTE = 2'b00,
        OP_POP_BYTE  = 2'b01,
        OP_PUSH_RET  = 2'b10,
        OP_POP_RET   = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_CALL_HI = 2'b01,
        ST_RET_LO  = 2'b10
    } stk_state_e;

endpackage

// File: rtl/stkptr_reg.sv
// Pointer register: holds the stack pointer as a low byte plus an optional
// high byte, and applies software writes or single steps of +1 / -1.
// Assumes: the sequencer never asks for a step in a cycle with a software
// write, so the write strobes and step_en are mutually exclusive.
module stkptr_reg #(
    parameter int SP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_wr_lo,
    input  logic            sw_wr_hi,
    input  logic [7:0]      sw_wdata,
    input  logic            step_en,
    input  logic            step_up,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_inc,
    output logic [7:0]      rd_lo,
    output logic [7:0]      rd_hi
);

    logic [SP_W-1:0] stepped;
    logic [7:0]      lo_q;

    // Neighbour values: one above and the value after the requested step.
    always_comb begin
        sp_inc  = sp + SP_W'(1);
        stepped = step_up ? sp_inc : (sp - SP_W'(1));
    end

    // Low byte: software write has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= 8'h00;
        else if (sw_wr_lo)
            lo_q <= sw_wdata;
        else if (step_en)
            lo_q <= stepped[7:0];
    end

    assign rd_lo = lo_q;

    generate
        if (SP_W > 8) begin : g_high
            logic [SP_W-9:0] hi_q;

            // High byte: software write has priority over a step.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hi_q <= '0;
                else if (sw_wr_hi)
                    hi_q <= sw_wdata[SP_W-9:0];
                else if (step_en)
                    hi_q <= stepped[SP_W-1:8];
            end

            assign sp    = {hi_q, lo_q};
            assign rd_hi = 8'(hi_q);
        end else begin : g_low_only
            assign sp    = lo_q;
            assign rd_hi = 8'h00;
        end
    endgenerate

endmodule

// File: rtl/stkptr_seq.sv
// Transfer sequencer: accepts one stack request at a time, drives the SRAM
// strobes for each byte, orders the two bytes of a return address, and
// returns popped data on registered outputs.
// Assumes: SRAM read data is valid in the same cycle as mem_addr/mem_re;
// sp_addr and sp_up_addr are the pointer and pointer+1, already wrapped to
// the pointer width and zero-extended to 16 bits.
module stkptr_seq
    import stkptr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_wdata,
    input  logic [15:0] req_addr,
    input  logic        sw_hit,
    input  logic [15:0] sp_addr,
    input  logic [15:0] sp_up_addr,
    input  logic [7:0]  mem_rdata,
    output logic        req_ready,
    output logic        busy,
    output logic        step_en,
    output logic        step_up,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    output logic        pop_valid,
    output logic [7:0]  pop_byte,
    output logic        ret_valid,
    output logic [15:0] ret_addr
);

    stk_state_e state_q, state_d;
    logic [7:0] hold_q;
    logic       load_hold_call, load_hold_ret, fire_pop, fire_ret;

    // Next-state, SRAM strobes and pointer step for the current cycle.
    always_comb begin
        state_d        = state_q;
        mem_addr       = sp_addr;
        mem_wdata      = 8'h00;
        mem_we         = 1'b0;
        mem_re         = 1'b0;
        step_en        = 1'b0;
        step_up        = 1'b0;
        load_hold_call = 1'b0;
        load_hold_ret  = 1'b0;
        fire_pop       = 1'b0;
        fire_ret       = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (rst_n && req_valid && !sw_hit) begin
                    step_en = 1'b1;
                    case (stk_op_e'(req_op))
                        OP_PUSH_BYTE: begin
                            mem_we    = 1'b1;
                            mem_wdata = req_wdata;
                        end
                        OP_POP_BYTE: begin
                            mem_re   = 1'b1;
                            mem_addr = sp_up_addr;
                            step_up  = 1'b1;
                            fire_pop = 1'b1;
                        end
                        OP_PUSH_RET: begin
                            mem_we         = 1'b1;
                            mem_wdata      = req_addr[7:0];
                            load_hold_call = 1'b1;
                            state_d        = ST_CALL_HI;
                        end
                        default: begin
                            mem_re        = 1'b1;
                            mem_addr      = sp_up_addr;
                            step_up       = 1'b1;
                            load_hold_ret = 1'b1;
                            state_d       = ST_RET_LO;
                        end
                    endcase
                end
            end
            ST_CALL_HI: begin
                state_d = ST_IDLE;
                if (!sw_hit) begin
                    mem_we    = 1'b1;
                    mem_wdata = hold_q;
                    step_en   = 1'b1;
                end
            end
            ST_RET_LO: begin
                state_d = ST_IDLE;
                if (!sw_hit) begin
                    mem_re   = 1'b1;
                    mem_addr = sp_up_addr;
                    step_en  = 1'b1;
                    step_up  = 1'b1;
                    fire_ret = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign req_ready = rst_n && (state_q == ST_IDLE) && !sw_hit;

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Holding byte: high address half for a push, high read byte for a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_q <= 8'h00;
        else if (load_hold_call) hold_q <= req_addr[15:8];
        else if (load_hold_ret)  hold_q <= mem_rdata;
    end

    // Registered result outputs and their one-cycle valid pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            pop_byte  <= 8'h00;
            ret_valid <= 1'b0;
            ret_addr  <= 16'h0000;
        end else begin
            pop_valid <= fire_pop;
            ret_valid <= fire_ret;
            if (fire_pop) pop_byte <= mem_rdata;
            if (fire_ret) ret_addr <= {hold_q, mem_rdata};
        end
    end

    // R4 / R5: a two-byte transfer spends exactly one cycle busy.
    assert_two_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R7 / R8: a software write suppresses every SRAM strobe in its cycle.
    assert_sw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hit |-> (!mem_we && !mem_re && !req_ready));

    // R10: no request is accepted while busy.
    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R5: a returned address always follows a read cycle.
    assert_ret_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(mem_re));

endmodule

// File: rtl/stkptr_engine.sv
// Stack pointer engine top: joins the pointer register and the transfer
// sequencer, and exposes the pointer as two software-visible bytes.
// Assumes: HAS_HIGH_BYTE = 0 builds an 8-bit pointer with no high register.
module stkptr_engine #(
    parameter bit HAS_HIGH_BYTE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_wdata,
    input  logic [15:0] req_addr,
    output logic        req_ready,
    output logic        busy,
    input  logic        sw_wr_lo,
    input  logic        sw_wr_hi,
    input  logic [7:0]  sw_wdata,
    output logic [7:0]  sw_rd_lo,
    output logic [7:0]  sw_rd_hi,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic        pop_valid,
    output logic [7:0]  pop_byte,
    output logic        ret_valid,
    output logic [15:0] ret_addr
);

    localparam int SP_W = HAS_HIGH_BYTE ? 16 : 8;

    logic [SP_W-1:0] sp, sp_inc;
    logic            sw_hit, hi_wr_eff;
    logic            step_en, step_up;

    // A high-byte write counts only when the high register exists.
    assign hi_wr_eff = HAS_HIGH_BYTE && sw_wr_hi;
    assign sw_hit    = sw_wr_lo || hi_wr_eff;

    stkptr_reg #(.SP_W(SP_W)) reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr_lo (sw_wr_lo),
        .sw_wr_hi (hi_wr_eff),
        .sw_wdata (sw_wdata),
        .step_en  (step_en),
        .step_up  (step_up),
        .sp       (sp),
        .sp_inc   (sp_inc),
        .rd_lo    (sw_rd_lo),
        .rd_hi    (sw_rd_hi)
    );

    stkptr_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_wdata  (req_wdata),
        .req_addr   (req_addr),
        .sw_hit     (sw_hit),
        .sp_addr    (16'(sp)),
        .sp_up_addr (16'(sp_inc)),
        .mem_rdata  (mem_rdata),
        .req_ready  (req_ready),
        .busy       (busy),
        .step_en    (step_en),
        .step_up    (step_up),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .pop_valid  (pop_valid),
        .pop_byte   (pop_byte),
        .ret_valid  (ret_valid),
        .ret_addr   (ret_addr)
    );

    // R2 / R4: after a write the pointer sits one below the written address.
    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == SP_W'($past(mem_addr[SP_W-1:0]) - 1'b1)));

    // R3 / R5: after a read the pointer equals the address just read.
    assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp == $past(mem_addr[SP_W-1:0])));

    // R11: address bits above the pointer width stay zero.
    assert_addr_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> ((mem_addr >> SP_W) == 16'h0000));

endmodule

// File: tb/stkptr_engine_tb_top.sv
`timescale 1ns/1ps
module stkptr_engine_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Main instance signals
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [7:0]  req_wdata = 8'h00;
    logic [15:0] req_addr = 16'h0000;
    logic        sw_wr_lo = 1'b0, sw_wr_hi = 1'b0;
    logic [7:0]  sw_wdata = 8'h00;
    logic        req_ready, busy, mem_we, mem_re, pop_valid, ret_valid;
    logic [7:0]  sw_rd_lo, sw_rd_hi, mem_wdata, mem_rdata, pop_byte;
    logic [15:0] mem_addr, ret_addr;

    // Small instance signals
    logic        s_req_valid = 1'b0;
    logic [1:0]  s_req_op = 2'b00;
    logic [7:0]  s_req_wdata = 8'h00;
    logic        s_sw_wr_lo = 1'b0, s_sw_wr_hi = 1'b0;
    logic [7:0]  s_sw_wdata = 8'h00;
    logic        s_ready, s_busy, s_we, s_re, s_pop_valid, s_ret_valid;
    logic [7:0]  s_rd_lo, s_rd_hi, s_wdata, s_pop_byte;
    logic [15:0] s_addr, s_ret_addr;

    stkptr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_wdata(req_wdata), .req_addr(req_addr), .req_ready(req_ready),
        .busy(busy), .sw_wr_lo(sw_wr_lo), .sw_wr_hi(sw_wr_hi),
        .sw_wdata(sw_wdata), .sw_rd_lo(sw_rd_lo), .sw_rd_hi(sw_rd_hi),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .pop_valid(pop_valid),
        .pop_byte(pop_byte), .ret_valid(ret_valid), .ret_addr(ret_addr)
    );

    stkptr_engine #(.HAS_HIGH_BYTE(1'b0)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_op(s_req_op),
        .req_wdata(s_req_wdata), .req_addr(16'h0000), .req_ready(s_ready),
        .busy(s_busy), .sw_wr_lo(s_sw_wr_lo), .sw_wr_hi(s_sw_wr_hi),
        .sw_wdata(s_sw_wdata), .sw_rd_lo(s_rd_lo), .sw_rd_hi(s_rd_hi),
        .mem_addr(s_addr), .mem_wdata(s_wdata), .mem_we(s_we),
        .mem_re(s_re), .mem_rdata(8'h5A), .pop_valid(s_pop_valid),
        .pop_byte(s_pop_byte), .ret_valid(s_ret_valid), .ret_addr(s_ret_addr)
    );

    // Bench SRAM indexed by the low address byte; tests keep windows apart.
    logic [7:0] sram [0:255];
    logic [7:0] ref_mem [0:255];
    initial for (int i = 0; i < 256; i++) begin sram[i] = 8'h00; ref_mem[i] = 8'h00; end
    always @(posedge clk) if (mem_we) sram[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = sram[mem_addr[7:0]];

    logic [15:0] exp_sp = 16'h0000;
    logic [7:0]  exp_pop[$];
    logic [15:0] exp_ret[$];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_sp(input string tag);
        chk(tag, {sw_rd_hi, sw_rd_lo}, exp_sp);
    endtask

    // Monitor: compares returned results against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (exp_pop.size() == 0) chk("R3 unexpected pop_valid", 16'h1, 16'h0);
            else chk("R3 pop_byte", {8'h00, pop_byte}, {8'h00, exp_pop.pop_front()});
        end
        if (rst_n && ret_valid) begin
            if (exp_ret.size() == 0) chk("R5 unexpected ret_valid", 16'h1, 16'h0);
            else chk("R5 ret_addr", ret_addr, exp_ret.pop_front());
        end
    end

    task automatic sw_write(input bit lo_en, input bit hi_en, input logic [7:0] d);
        sw_wr_lo = lo_en; sw_wr_hi = hi_en; sw_wdata = d;
        if (lo_en) exp_sp[7:0] = d;
        if (hi_en) exp_sp[15:8] = d;
        @(negedge clk);
        sw_wr_lo = 1'b0; sw_wr_hi = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        req_valid = 1'b1; req_op = 2'b00; req_wdata = b;
        #1;
        chk("R2 mem_we", {15'h0, mem_we}, 16'h1);
        chk("R2 mem_addr", mem_addr, exp_sp);
        chk("R2 mem_wdata", {8'h00, mem_wdata}, {8'h00, b});
        ref_mem[exp_sp[7:0]] = b;
        exp_sp = exp_sp - 16'h1;
        @(negedge clk);
        req_valid = 1'b0;
        chk_sp("R2 pointer after push");
    endtask

    task automatic pop_byte_op();
        req_valid = 1'b1; req_op = 2'b01;
        #1;
        chk("R3 mem_re", {15'h0, mem_re}, 16'h1);
        chk("R3 mem_addr", mem_addr, exp_sp + 16'h1);
        exp_sp = exp_sp + 16'h1;
        exp_pop.push_back(ref_mem[exp_sp[7:0]]);
        @(negedge clk);
        req_valid = 1'b0;
        chk_sp("R3 pointer after pop");
    endtask

    task automatic call_push(input logic [15:0] a, input bit keep_req);
        req_valid = 1'b1; req_op = 2'b10; req_addr = a;
        #1;
        chk("R4 first mem_addr", mem_addr, exp_sp);
        chk("R4 first data", {8'h00, mem_wdata}, {8'h00, a[7:0]});
        ref_mem[exp_sp[7:0]] = a[7:0];
        exp_sp = exp_sp - 16'h1;
        @(negedge clk);
        req_valid = keep_req; req_op = 2'b00; req_wdata = 8'hEE;
        #1;
        chk("R4 busy in second cycle", {15'h0, busy}, 16'h1);
        chk("R10 ready low while busy", {15'h0, req_ready}, 16'h0);
        chk("R4 second mem_addr", mem_addr, exp_sp);
        chk("R4 second data", {8'h00, mem_wdata}, {8'h00, a[15:8]});
        ref_mem[exp_sp[7:0]] = a[15:8];
        exp_sp = exp_sp - 16'h1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 busy clear", {15'h0, busy}, 16'h0);
        chk_sp(keep_req ? "R10 pointer moved by call only" : "R4 pointer after call");
    endtask

    task automatic ret_pop();
        logic [7:0] hi;
        req_valid = 1'b1; req_op = 2'b11;
        #1;
        chk("R5 first mem_addr", mem_addr, exp_sp + 16'h1);
        exp_sp = exp_sp + 16'h1;
        hi = ref_mem[exp_sp[7:0]];
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R5 busy in second cycle", {15'h0, busy}, 16'h1);
        chk("R5 second mem_addr", mem_addr, exp_sp + 16'h1);
        exp_sp = exp_sp + 16'h1;
        exp_ret.push_back({hi, ref_mem[exp_sp[7:0]]});
        @(negedge clk);
        chk_sp("R5 pointer after return");
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk_sp("R1 pointer after reset");
        chk("R1 ready", {15'h0, req_ready}, 16'h1);
        chk("R1 busy", {15'h0, busy}, 16'h0);
        chk("R1 no strobes", {14'h0, mem_we, mem_re}, 16'h0);
        @(negedge clk);

        // R6: software register access
        sw_write(1'b0, 1'b1, 8'h01);
        sw_write(1'b1, 1'b0, 8'hF0);
        chk_sp("R6 pointer after byte writes");

        // R2 / R3: byte push and pop, LIFO order
        push_byte(8'hA1);
        push_byte(8'hB2);
        pop_byte_op();
        pop_byte_op();
        @(negedge clk);

        // R4 / R5: return address push and pop
        call_push(16'h1234, 1'b0);
        ret_pop();
        // R10: request held during busy is ignored
        call_push(16'hBEEF, 1'b1);
        @(negedge clk);
        ret_pop();
        @(negedge clk);

        // R7: software write collides with a push in an idle cycle
        req_valid = 1'b1; req_op = 2'b00; req_wdata = 8'h99;
        sw_wr_lo = 1'b1; sw_wdata = 8'hC0;
        #1;
        chk("R7 ready low on collision", {15'h0, req_ready}, 16'h0);
        chk("R7 no write on collision", {15'h0, mem_we}, 16'h0);
        exp_sp[7:0] = 8'hC0;
        @(negedge clk);
        req_valid = 1'b0; sw_wr_lo = 1'b0;
        chk_sp("R7 pointer holds written value");

        // R8: software write during the second cycle of a call
        req_valid = 1'b1; req_op = 2'b10; req_addr = 16'h5566;
        #1;
        ref_mem[exp_sp[7:0]] = 8'h66;
        exp_sp = exp_sp - 16'h1;
        @(negedge clk);
        req_valid = 1'b0; sw_wr_hi = 1'b1; sw_wdata = 8'h03;
        #1;
        chk("R8 no write in abandoned cycle", {15'h0, mem_we}, 16'h0);
        exp_sp[15:8] = 8'h03;
        @(negedge clk);
        sw_wr_hi = 1'b0;
        chk("R8 idle after abandon", {15'h0, busy}, 16'h0);
        chk_sp("R8 pointer after abandon");

        // R9: wrap at both ends
        sw_write(1'b1, 1'b1, 8'hFF);
        pop_byte_op();
        push_byte(8'h5C);
        pop_byte_op();
        @(negedge clk);

        // R11: small build without high register
        s_sw_wr_lo = 1'b1; s_sw_wr_hi = 1'b1; s_sw_wdata = 8'hAB;
        @(negedge clk);
        s_sw_wr_lo = 1'b0; s_sw_wr_hi = 1'b0;
        chk("R11 high read is zero", {8'h00, s_rd_hi}, 16'h0000);
        chk("R11 low written", {8'h00, s_rd_lo}, 16'h00AB);
        s_sw_wr_lo = 1'b1; s_sw_wdata = 8'h00;
        @(negedge clk);
        s_sw_wr_lo = 1'b0;
        s_req_valid = 1'b1; s_req_op = 2'b00; s_req_wdata = 8'h77;
        #1;
        chk("R11 push address", s_addr, 16'h0000);
        @(negedge clk);
        s_req_valid = 1'b0;
        chk("R11 wrap to 0xFF", {s_rd_hi, s_rd_lo}, 16'h00FF);
        s_req_valid = 1'b1; s_req_op = 2'b01;
        #1;
        chk("R11 pop address wraps", s_addr, 16'h0000);
        @(negedge clk);
        s_req_valid = 1'b0;
        chk("R11 pop valid", {15'h0, s_pop_valid}, 16'h1);
        chk("R11 pop byte", {8'h00, s_pop_byte}, 16'h005A);
        chk("R11 pointer back to 0", {s_rd_hi, s_rd_lo}, 16'h0000);

        repeat (3) @(negedge clk);
        chk("R3 pop queue drained", 16'(exp_pop.size()), 16'h0);
        chk("R5 return queue drained", 16'(exp_ret.size()), 16'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule